// File: doc/BRIEF.md
# FPU exception status controller

This block keeps the exception part of a floating-point status/control word and decides, for each completed floating-point operation, whether the pipeline must stop and request a floating-point trap. Every operation hands over five raw exception indications (invalid, divide-by-zero, overflow, underflow, inexact), a 2-bit operation class, and a marker that says whether any source operand was a quiet NaN or an infinity. The block filters the indications by what the operation class can produce. It records the result in a per-operation cause field and in an accumulating flag field. It compares the result with the enable field and, in the same cycle, drives a trap request and a halt signal.

Software sees the fields through a 32-bit register port. Reads are combinational from the stored state, and a write updates cause, enable, flag and the special-operand trap mode together on the next clock edge. The arithmetic units and the CPU trap entry sequence sit outside this block.

Top module: `fpu_exc_ctrl`

## Requirements
- R1: Register layout on `reg_rdata`: cause in bits [16:12], enable in bits [11:7], flag in bits [6:2], the special-operand trap mode in bit 18, all other bits zero. Inside each 5-bit field, bit 0 is invalid, bit 1 divide-by-zero, bit 2 overflow, bit 3 underflow and bit 4 inexact. A write with `reg_we` high loads all four writable parts from `reg_wdata` at the next clock edge. All state is zero after reset.
- R2: `exc_req` is high in a cycle only when `op_valid` is high and at least one effective exception of that operation has its enable bit set. It is low in every other cycle.
- R3: On every cycle with `op_valid` high, the cause field is replaced by that operation's effective exceptions, and earlier cause bits are dropped.
- R4: Flag bits are ORed with each operation's effective exceptions whether or not a trap is requested. A flag bit goes to 0 only through a register write.
- R5: Class codes on `op_class`: 0 = arithmetic (divide-by-zero masked), 1 = divide (nothing masked), 2 = compare (only invalid kept), 3 = conversion (only invalid and inexact kept). Masked indications reach neither cause, flag nor the request.
- R6: `op_halt` equals `exc_req` in every cycle.
- R7: When the mode bit is 1, `op_valid` with `op_src_special` high adds invalid to the effective exceptions. With invalid enabled this raises a request. With the mode bit 0, `op_src_special` has no effect.
- R8: When a register write and `op_valid` fall in the same cycle, enable and mode come from the write, while cause and flag take the hardware update (flag = old flag OR effective exceptions). The request in that cycle uses the enable value held before the write.
- R9: Enable and mode never change except through a register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation result strobe |
| op_exc | input | 5 | Raw exception indications of the operation |
| op_class | input | 2 | Operation class code |
| op_src_special | input | 1 | A source operand was a quiet NaN or an infinity |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| exc_req | output | 1 | Floating-point trap request |
| op_halt | output | 1 | Stop the floating-point pipeline |

## Verification
The assertions assume that `op_class` carries a defined 2-bit code whenever `op_valid` is high. They also assume that `reg_we` and `op_valid` are sampled as clean single-cycle strobes. The flag and enable checks compare state one cycle apart, so they rely on the inputs being known at every edge after reset. The directed stimulus meets these assumptions by driving every input to a known value at the falling edge and returning the strobes to 0 after each operation or write. It covers every class code, colliding write and operation cycles, and both settings of the special-operand mode.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    localparam int EXC_W   = 5;
    localparam int REG_W   = 32;
    localparam int CLS_W   = 2;
    localparam int CAUSE_LSB = 12;
    localparam int EN_LSB    = 7;
    localparam int FLAG_LSB  = 2;
    localparam int MODE_BIT  = 18;

    localparam int XV = 0;
    localparam int XZ = 1;
    localparam int XO = 2;
    localparam int XU = 3;
    localparam int XI = 4;

    typedef enum logic [CLS_W-1:0] {
        CLS_ARITH = 2'd0,
        CLS_DIV   = 2'd1,
        CLS_CMP   = 2'd2,
        CLS_CONV  = 2'd3
    } op_cls_e;

    typedef struct packed {
        logic [EXC_W-1:0] cause;
        logic [EXC_W-1:0] enable;
        logic [EXC_W-1:0] flag;
        logic             mode;
    } exc_state_t;

    function automatic logic [EXC_W-1:0] cls_allow(input op_cls_e c);
        logic [EXC_W-1:0] m;
        case (c)
            CLS_ARITH: m = ~(EXC_W'(1) << XZ);
            CLS_DIV:   m = '1;
            CLS_CMP:   m = EXC_W'(1) << XV;
            default:   m = (EXC_W'(1) << XV) | (EXC_W'(1) << XI);
        endcase
        return m;
    endfunction
endpackage

// File: rtl/fpx_filter.sv
module fpx_filter
    import fpx_pkg::*;
(
    input  logic [EXC_W-1:0] raw_exc,
    input  logic [CLS_W-1:0] cls,
    input  logic             special,
    input  logic             mode,
    output logic [EXC_W-1:0] eff_exc
);
    logic [EXC_W-1:0] allow;
    logic             inject_inv;

    always_comb begin
        allow      = cls_allow(op_cls_e'(cls));
        inject_inv = mode & special;
    end

    for (genvar i = 0; i < EXC_W; i++) begin : g_bit
        if (i == XV) begin : g_inv
            assign eff_exc[i] = (raw_exc[i] & allow[i]) | inject_inv;
        end else begin : g_other
            assign eff_exc[i] = raw_exc[i] & allow[i];
        end
    end
endmodule

// File: rtl/fpx_trap.sv
module fpx_trap
    import fpx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic [EXC_W-1:0] eff_exc,
    input  logic [EXC_W-1:0] enable,
    output logic             req,
    output logic             halt
);
    always_comb begin
        req  = valid & (|(eff_exc & enable));
        halt = req;
    end

    // R2
    req_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> valid);

    // R6
    halt_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt == req);
endmodule

// File: rtl/fpu_exc_ctrl.sv
module fpu_exc_ctrl
    import fpx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [4:0]       op_exc,
    input  logic [1:0]       op_class,
    input  logic             op_src_special,
    input  logic             reg_we,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             exc_req,
    output logic             op_halt
);
    exc_state_t       st_d, st_q;
    logic [EXC_W-1:0] eff;
    logic             unused_wbits;

    assign unused_wbits = ^{reg_wdata[REG_W-1:MODE_BIT+1],
                            reg_wdata[MODE_BIT-1:CAUSE_LSB+EXC_W],
                            reg_wdata[FLAG_LSB-1:0]};

    fpx_filter u_filter (
        .raw_exc (op_exc),
        .cls     (op_class),
        .special (op_src_special),
        .mode    (st_q.mode),
        .eff_exc (eff)
    );

    fpx_trap u_trap (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (op_valid),
        .eff_exc (eff),
        .enable  (st_q.enable),
        .req     (exc_req),
        .halt    (op_halt)
    );

    always_comb begin
        st_d = st_q;
        if (reg_we) begin
            st_d.cause  = reg_wdata[CAUSE_LSB +: EXC_W];
            st_d.enable = reg_wdata[EN_LSB    +: EXC_W];
            st_d.flag   = reg_wdata[FLAG_LSB  +: EXC_W];
            st_d.mode   = reg_wdata[MODE_BIT];
        end
        if (op_valid) begin
            st_d.cause = eff;
            st_d.flag  = st_q.flag | eff;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        reg_rdata[CAUSE_LSB +: EXC_W] = st_q.cause;
        reg_rdata[EN_LSB    +: EXC_W] = st_q.enable;
        reg_rdata[FLAG_LSB  +: EXC_W] = st_q.flag;
        reg_rdata[MODE_BIT]           = st_q.mode;
    end

    // R4
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> ((st_q.flag & $past(st_q.flag)) == $past(st_q.flag)));

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> ($stable(st_q.enable) && $stable(st_q.mode)));

    // R5
    cmp_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_class == CLS_CMP) |=> (st_q.cause[XI:XO] == '0));

    // R7
    mode_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && st_q.mode && op_src_special && st_q.enable[XV]) |-> exc_req);

    // R8
    collide_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && reg_we) |=> (reg_rdata[EN_LSB +: EXC_W] == $past(reg_wdata[EN_LSB +: EXC_W])));
endmodule

// File: tb/sim_fpu_exc_ctrl.sv
module sim_fpu_exc_ctrl;
    localparam int CLK_P = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        op_valid = 0;
    logic [4:0]  op_exc = 0;
    logic [1:0]  op_class = 0;
    logic        op_src_special = 0;
    logic        reg_we = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        exc_req, op_halt;

    int total = 0;
    int bad = 0;

    logic [4:0] m_cause = 0, m_en = 0, m_flag = 0;
    logic       m_mode = 0;

    fpu_exc_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_exc(op_exc),
        .op_class(op_class), .op_src_special(op_src_special), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .exc_req(exc_req),
        .op_halt(op_halt)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [31:0] pack(input logic [4:0] c, input logic [4:0] e,
                                         input logic [4:0] f, input logic q);
        logic [31:0] v = 0;
        v[16:12] = c; v[11:7] = e; v[6:2] = f; v[18] = q;
        return v;
    endfunction

    function automatic logic [4:0] keep(input logic [1:0] c);
        case (c)
            2'd0: return 5'b11101;
            2'd1: return 5'b11111;
            2'd2: return 5'b00001;
            default: return 5'b10001;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_reg(input string req);
        check(req, reg_rdata, pack(m_cause, m_en, m_flag, m_mode));
    endtask

    // one cycle: optional write and optional op together
    task automatic cycle(input logic we, input logic [31:0] wd, input logic v,
                         input logic [4:0] ex, input logic [1:0] cl, input logic sp,
                         input string req);
        logic [4:0] eff;
        logic       r;
        @(negedge clk);
        reg_we = we; reg_wdata = wd; op_valid = v; op_exc = ex;
        op_class = cl; op_src_special = sp;
        eff = ex & keep(cl);
        if (m_mode && sp) eff[0] = 1'b1;
        r = v && ((eff & m_en) != 0);
        #1;
        check({req, " req"}, {31'b0, exc_req}, {31'b0, r});
        check("R6 halt", {31'b0, op_halt}, {31'b0, exc_req});
        if (we) begin
            m_cause = wd[16:12]; m_en = wd[11:7]; m_flag = wd[6:2]; m_mode = wd[18];
        end
        if (v) begin
            m_cause = eff;
            m_flag  = (we ? m_flag_prev : m_flag) | eff;
        end
        @(negedge clk);
        reg_we = 0; op_valid = 0; op_exc = 0; op_src_special = 0;
        #1;
        check_reg({req, " reg"});
    endtask

    logic [4:0] m_flag_prev;

    task automatic wr(input logic [31:0] wd, input string req);
        m_flag_prev = m_flag;
        cycle(1, wd, 0, 0, 0, 0, req);
    endtask

    task automatic op(input logic [4:0] ex, input logic [1:0] cl, input logic sp, input string req);
        m_flag_prev = m_flag;
        cycle(0, 0, 1, ex, cl, sp, req);
    endtask

    task automatic t_reset;
        check("R1 reset rdata", reg_rdata, 32'h0);
        check("R2 reset req", {31'b0, exc_req}, 32'h0);
    endtask

    task automatic t_layout;
        wr(pack(5'b10101, 5'b01010, 5'b11001, 1'b1) | 32'hFFF8_0003, "R1 write");
        wr(32'h0, "R1 clear");
    endtask

    task automatic t_cause;
        op(5'b00100, 2'd0, 0, "R3 ovf");
        op(5'b10000, 2'd0, 0, "R3 inexact");
        op(5'b00000, 2'd0, 0, "R3 none");
    endtask

    task automatic t_sticky;
        op(5'b01000, 2'd1, 0, "R4 unf");
        op(5'b00010, 2'd1, 0, "R4 dz");
        op(5'b00000, 2'd1, 0, "R4 keep");
        wr(32'h0, "R4 clear");
    endtask

    task automatic t_enable;
        wr(pack(0, 5'b00010, 0, 0), "R2 en dz");
        op(5'b00100, 2'd1, 0, "R2 masked by enable");
        op(5'b00010, 2'd1, 0, "R2 dz trap");
        op(5'b00010, 2'd0, 0, "R5 arith masks dz");
        m_flag_prev = m_flag;
        cycle(0, 0, 0, 5'b11111, 2'd1, 0, "R2 no valid");
    endtask

    task automatic t_class;
        wr(pack(0, 5'b11111, 0, 0), "R5 en all");
        op(5'b11111, 2'd2, 0, "R5 compare");
        op(5'b11111, 2'd3, 0, "R5 conv");
        op(5'b11110, 2'd2, 0, "R5 compare none");
    endtask

    task automatic t_mode;
        wr(pack(0, 5'b00001, 0, 0), "R7 mode off");
        op(0, 2'd0, 1, "R7 special ignored");
        wr(pack(0, 5'b00001, 0, 1), "R7 mode on");
        op(0, 2'd0, 1, "R7 special trap");
        wr(pack(0, 5'b00000, 0, 1), "R7 mode on no en");
        op(0, 2'd2, 1, "R7 special no trap");
        op(0, 2'd2, 0, "R9 cfg kept");
    endtask

    task automatic t_collide;
        wr(pack(0, 5'b00100, 5'b00001, 0), "R8 setup");
        m_flag_prev = m_flag;
        cycle(1, pack(5'b11111, 5'b10000, 5'b00000, 1), 1, 5'b00100, 2'd0, 0, "R8 collide");
        m_flag_prev = m_flag;
        cycle(1, pack(0, 0, 0, 0), 1, 5'b10000, 2'd0, 0, "R8 collide new en");
    endtask

    initial begin
        fork
            begin
                #(CLK_P*3);
                @(negedge clk);
                t_reset();
                rst_n = 1;
                #(CLK_P*2);
                t_layout();
                t_cause();
                t_sticky();
                t_enable();
                t_class();
                t_mode();
                t_collide();
            end
            begin
                #(CLK_P*20000);
                total++; bad++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule